// File: doc/BRIEF.md
# Four-Channel DMA Register Port Block

This block is the software-visible side of a four-channel DMA controller in the classic PC style. A host reaches it over a narrow I/O bus: a 4-bit port number, an 8-bit write byte, a write strobe, a read strobe and a registered 8-bit read byte. Each channel keeps a 16-bit base and current address and a 16-bit base and current count. Because every port is only one byte wide, a single shared byte-pointer flip-flop chooses whether an access touches the low or the high half of a 16-bit register. The host sends the low byte first and then the high byte to the same port.

Ports 0x0 to 0x7 reach the channel registers. Ports 0x8 to 0xF hold the control functions: status and request, single and group mask, mode, pointer clear and master clear. The transfer engine sits outside this block. It sees each channel's mask bit, stored mode bits and current count. It sends back one step pulse per channel for each transfer it performs, and this block then advances the address and count of that channel and handles terminal count.

Top module: `dma_port_regs`

## Requirements
- R1: After synchronous active-high reset all four mask bits are 1, every stored mode field is 0, every address and count is 0, the pointer selects the low byte and `io_rdata` is 0.
- R2: Channel c has its address at port 2c and its count at port 2c+1. The first byte written after the pointer is cleared lands in bits [7:0] and the next in bits [15:8]. Every read or write at ports 0x0 to 0x7 toggles the shared pointer.
- R3: Any write to port 0xC forces the pointer to the low byte, whatever its state before.
- R4: A read of port 2c or 2c+1 returns the selected byte of the current address or count on `io_rdata` one cycle after `io_rd`. `io_rdata` holds its value when no read is made.
- R5: A write to port 0xA uses bits [1:0] as the channel. Bit 2 = 1 sets that channel's mask bit and bit 2 = 0 clears it. The other mask bits are left unchanged.
- R6: A write to port 0xE clears all mask bits. A write to port 0xF copies data bits [3:0] into mask bits [3:0].
- R7: A write to port 0xB uses bits [1:0] as the channel and stores data bits [7:2] as that channel's 6-bit mode field, which appears on `ch_mode[6c+5:6c]`. Mode field bit 2 (data 0x10) enables auto-initialise and mode field bit 3 (data 0x20) makes the address decrement. For example 0x44 gives I/O-to-memory single increment, 0x48 gives memory-to-I/O and 0xC0 gives cascade.
- R8: A write to port 0xD sets all mask bits, clears the pointer and clears the request and terminal-count state. It leaves modes, addresses and counts unchanged.
- R9: Each `xfer_step[c]` pulse on a channel whose count is not 0 lowers the current count by 1 and moves the current address by +1, or by -1 when mode bit 3 is set, with 16-bit wrap.
- R10: A step while the count is 0 is terminal count. It sets that channel's terminal-count flag. With auto-initialise the current address and count reload from base. Without it the count wraps to 0xFFFF, the address advances and the channel's mask bit is set.
- R11: A read of port 0x8 returns {request[3:0], terminal-count[3:0]} and clears the terminal-count flags. A write to port 0x9 uses bits [1:0] as the channel and sets that channel's request bit when bit 2 = 1 or clears it when bit 2 = 0.
- R12: Writing a byte of an address or count updates the base register and copies the whole new base value into the current register. A step on a channel is ignored in a cycle when that channel is being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_port | input | 4 | Register port number |
| io_wdata | input | 8 | Write byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access; ignored while io_wr is high |
| io_rdata | output | 8 | Registered read byte |
| xfer_step | input | 4 | One pulse per completed transfer, per channel |
| ch_mask | output | 4 | Per-channel mask bits (1 = disabled) |
| ch_mode | output | 24 | Stored 6-bit mode field per channel |
| ch_count | output | 64 | Current 16-bit count per channel |

## Verification
The register path is tested with full 16-bit loads through both byte halves. It is also tested with a deliberately desynchronised pointer that is then cleared, which separates a design that clears the pointer from one that only toggles it. Steps are applied with increment and decrement modes and across terminal count both with and without auto-initialise, so the reload, wrap and mask-on-terminal paths are each exercised on their own. Mask, request and status ports are driven with single-channel, group and master-clear patterns. A behavioural reference model is compared with every output on every clock.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int NCH     = 4;
  localparam int CH_W    = 2;
  localparam int BYTE_W  = 8;
  localparam int REG_W   = 2 * BYTE_W;
  localparam int PORT_W  = 4;
  localparam int MODE_W  = BYTE_W - CH_W;
  localparam int MB_AUTO = 2;
  localparam int MB_DEC  = 3;

  localparam logic [PORT_W-1:0] P_STATUS  = 4'h8;
  localparam logic [PORT_W-1:0] P_REQ     = 4'h9;
  localparam logic [PORT_W-1:0] P_SMASK   = 4'hA;
  localparam logic [PORT_W-1:0] P_MODE    = 4'hB;
  localparam logic [PORT_W-1:0] P_CLRPTR  = 4'hC;
  localparam logic [PORT_W-1:0] P_MCLR    = 4'hD;
  localparam logic [PORT_W-1:0] P_CLRMASK = 4'hE;
  localparam logic [PORT_W-1:0] P_MASKALL = 4'hF;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              step,
  input  logic              auto_init,
  input  logic              dec_addr,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output logic              tc_hit
);
  logic [REG_W-1:0] base_addr, base_cnt;
  logic [REG_W-1:0] addr_new, cnt_new, addr_adv;
  logic             step_ok;

  assign step_ok  = step & ~ld_addr & ~ld_cnt;
  assign tc_hit   = step_ok && (cur_cnt == '0);
  assign addr_new = hi_sel ? {wbyte, base_addr[BYTE_W-1:0]} : {base_addr[REG_W-1:BYTE_W], wbyte};
  assign cnt_new  = hi_sel ? {wbyte, base_cnt[BYTE_W-1:0]}  : {base_cnt[REG_W-1:BYTE_W], wbyte};
  assign addr_adv = dec_addr ? cur_addr - REG_W'(1) : cur_addr + REG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (ld_addr) begin
        base_addr <= addr_new;
        cur_addr  <= addr_new;
      end
      if (ld_cnt) begin
        base_cnt <= cnt_new;
        cur_cnt  <= cnt_new;
      end
      if (step_ok) begin
        if (tc_hit && auto_init) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= addr_adv;
          cur_cnt  <= cur_cnt - REG_W'(1);
        end
      end
    end
  end

  // R9: a non-terminal step lowers the count by one
  p_count_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (step_ok && cur_cnt != '0) |=> cur_cnt == $past(cur_cnt) - REG_W'(1));
  // R10: auto-initialise reloads the current registers at terminal count
  p_auto_reload_r10: assert property (@(posedge clk) disable iff (rst)
    (tc_hit && auto_init) |=> (cur_cnt == base_cnt && cur_addr == base_addr));
  // R12: loading a count copies the new base into the current register
  p_load_both_r12: assert property (@(posedge clk) disable iff (rst)
    ld_cnt |=> cur_cnt == base_cnt);
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_port_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                re,
  input  logic [PORT_W-1:0]   port,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [N-1:0]        tc_hit,
  output logic [N-1:0]        mask_o,
  output logic [N*MODE_W-1:0] mode_o,
  output logic [N-1:0]        auto_o,
  output logic [N-1:0]        dec_o,
  output logic                ptr_hi,
  output logic [2*N-1:0]      status_o
);
  logic [N-1:0]      mask_q, mask_port, req_q, tc_q, tc_set_mask;
  logic [MODE_W-1:0] mode_q [N];
  logic [CH_W-1:0]   sel;
  logic              reg_acc, mclr_w, rd_status;

  assign sel       = wdata[CH_W-1:0];
  assign reg_acc   = (we | re) & ~port[PORT_W-1];
  assign mclr_w    = we && port == P_MCLR;
  assign rd_status = re && port == P_STATUS;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mode
      assign mode_o[g*MODE_W +: MODE_W] = mode_q[g];
      assign auto_o[g]      = mode_q[g][MB_AUTO];
      assign dec_o[g]       = mode_q[g][MB_DEC];
      assign tc_set_mask[g] = tc_hit[g] & ~mode_q[g][MB_AUTO];
    end
  endgenerate

  always_comb begin
    mask_port = mask_q;
    if (we) begin
      case (port)
        P_SMASK:   mask_port[sel] = wdata[2];
        P_CLRMASK: mask_port = '0;
        P_MASKALL: mask_port = wdata[N-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      ptr_hi <= 1'b0;
      for (int c = 0; c < N; c++) mode_q[c] <= '0;
    end else if (mclr_w) begin
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      ptr_hi <= 1'b0;
    end else begin
      mask_q <= mask_port | tc_set_mask;
      tc_q   <= (rd_status ? '0 : tc_q) | tc_hit;
      if (we && port == P_CLRPTR) ptr_hi <= 1'b0;
      else if (reg_acc)           ptr_hi <= ~ptr_hi;
      if (we && port == P_REQ)  req_q[sel]  <= wdata[2];
      if (we && port == P_MODE) mode_q[sel] <= wdata[BYTE_W-1:CH_W];
    end
  end

  assign mask_o   = mask_q;
  assign status_o = {req_q, tc_q};

  // R2: every channel-register access flips the pointer
  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    reg_acc |=> ptr_hi != $past(ptr_hi));
  // R3: pointer clear
  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (we && port == P_CLRPTR) |=> !ptr_hi);
  // R5: single-channel mask write
  p_smask_r5: assert property (@(posedge clk) disable iff (rst)
    (we && port == P_SMASK && tc_hit == '0) |=> mask_o[$past(sel)] == $past(wdata[2]));
  // R6: clear-mask write
  p_clrmask_r6: assert property (@(posedge clk) disable iff (rst)
    (we && port == P_CLRMASK && tc_hit == '0) |=> mask_o == '0);
  // R8: master clear
  p_mclr_r8: assert property (@(posedge clk) disable iff (rst)
    mclr_w |=> (mask_o == '1 && !ptr_hi && status_o == '0));
endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
  import dma_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PORT_W-1:0]     io_port,
  input  logic [BYTE_W-1:0]     io_wdata,
  input  logic                  io_wr,
  input  logic                  io_rd,
  output logic [BYTE_W-1:0]     io_rdata,
  input  logic [NCH-1:0]        xfer_step,
  output logic [NCH-1:0]        ch_mask,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [NCH*REG_W-1:0]  ch_count
);
  logic              rd_ok, is_chan, is_cnt, ptr_hi;
  logic [CH_W-1:0]   chan_sel;
  logic [REG_W-1:0]  cur_addr [NCH];
  logic [REG_W-1:0]  cur_cnt  [NCH];
  logic [NCH-1:0]    tc_hit, auto_init, dec_addr;
  logic [2*NCH-1:0]  status;
  logic [REG_W-1:0]  rd_word;
  logic [BYTE_W-1:0] rd_byte;

  assign rd_ok    = io_rd & ~io_wr;
  assign is_chan  = ~io_port[PORT_W-1];
  assign is_cnt   = io_port[0];
  assign chan_sel = io_port[CH_W:1];

  dma_ctrl_regs #(.N(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .we(io_wr), .re(rd_ok), .port(io_port), .wdata(io_wdata),
    .tc_hit(tc_hit), .mask_o(ch_mask), .mode_o(ch_mode), .auto_o(auto_init),
    .dec_o(dec_addr), .ptr_hi(ptr_hi), .status_o(status)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      logic sel_here;
      assign sel_here = io_wr & is_chan & (chan_sel == CH_W'(c));
      dma_chan_regs #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_chan (
        .clk(clk), .rst(rst), .ld_addr(sel_here & ~is_cnt), .ld_cnt(sel_here & is_cnt),
        .hi_sel(ptr_hi), .wbyte(io_wdata), .step(xfer_step[c]),
        .auto_init(auto_init[c]), .dec_addr(dec_addr[c]),
        .cur_addr(cur_addr[c]), .cur_cnt(cur_cnt[c]), .tc_hit(tc_hit[c])
      );
      assign ch_count[c*REG_W +: REG_W] = cur_cnt[c];
    end
  endgenerate

  always_comb begin
    rd_word = is_cnt ? cur_cnt[chan_sel] : cur_addr[chan_sel];
    if (is_chan)                   rd_byte = ptr_hi ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    else if (io_port == P_STATUS)  rd_byte = BYTE_W'(status);
    else                           rd_byte = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (rd_ok) io_rdata <= rd_byte;
  end

  // R4: read data only moves on a read
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |=> $stable(io_rdata));
endmodule

// File: tb/dma_port_regs_bench.sv
module dma_port_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic [3:0]  io_port = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_rdata;
  logic [3:0]  xfer_step = 0;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] ch_count;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_port_regs u_dma_port_regs (
    .clk(clk), .rst(rst), .io_port(io_port), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .xfer_step(xfer_step), .ch_mask(ch_mask),
    .ch_mode(ch_mode), .ch_count(ch_count)
  );

  // behavioural reference model
  int m_ba[4], m_ca[4], m_bc[4], m_cc[4], m_mode[4];
  int m_mask, m_tc, m_req, m_ff, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin m_ba[c]=0; m_ca[c]=0; m_bc[c]=0; m_cc[c]=0; m_mode[c]=0; end
      m_mask = 15; m_tc = 0; m_req = 0; m_ff = 0; m_rd = 0;
    end else begin
      int ts, ms, ldch, p, d, ch, v;
      p = io_port; d = io_wdata; ts = 0; ms = 0;
      ldch = (io_wr && p < 8) ? p / 2 : -1;
      if (io_rd && !io_wr) begin
        if (p < 8) begin
          v = (p % 2) ? m_cc[p/2] : m_ca[p/2];
          m_rd = m_ff ? (v >> 8) & 255 : v & 255;
        end else if (p == 8) m_rd = (m_req << 4) | m_tc;
        else m_rd = 0;
      end
      for (int c = 0; c < 4; c++) if (xfer_step[c] && c != ldch) begin
        if (m_cc[c] == 0) begin
          ts |= 1 << c;
          if (m_mode[c] & 4) begin m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c]; continue; end
          ms |= 1 << c;
        end
        m_cc[c] = (m_cc[c] - 1) & 16'hFFFF;
        m_ca[c] = ((m_mode[c] & 8) ? m_ca[c] - 1 : m_ca[c] + 1) & 16'hFFFF;
      end
      ch = d & 3;
      if (io_wr && p == 13) begin
        m_mask = 15; m_ff = 0; m_tc = 0; m_req = 0;
      end else begin
        if (io_wr) begin
          if (p < 8) begin
            if (p % 2) begin
              v = m_ff ? (m_bc[p/2] & 255) | (d << 8) : (m_bc[p/2] & 16'hFF00) | d;
              m_bc[p/2] = v; m_cc[p/2] = v;
            end else begin
              v = m_ff ? (m_ba[p/2] & 255) | (d << 8) : (m_ba[p/2] & 16'hFF00) | d;
              m_ba[p/2] = v; m_ca[p/2] = v;
            end
            m_ff ^= 1;
          end
          case (p)
            9:  m_req = (d & 4) ? m_req | (1 << ch) : m_req & ~(1 << ch);
            10: m_mask = (d & 4) ? m_mask | (1 << ch) : m_mask & ~(1 << ch);
            11: m_mode[ch] = d >> 2;
            12: m_ff = 0;
            14: m_mask = 0;
            15: m_mask = d & 15;
            default: ;
          endcase
        end else if (io_rd) begin
          if (p < 8) m_ff ^= 1;
          if (p == 8) m_tc = 0;
        end
        m_mask |= ms;
        m_tc |= ts;
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) if (!rst && !done) begin
    checks++;
    if (ch_mask !== m_mask[3:0]) begin errors++; $display("FAIL R5 mask got %h exp %h", ch_mask, m_mask[3:0]); end
    for (int c = 0; c < 4; c++) begin
      if (ch_mode[c*6 +: 6] !== m_mode[c][5:0]) begin errors++; $display("FAIL R7 mode%0d got %h exp %h", c, ch_mode[c*6 +: 6], m_mode[c][5:0]); end
      if (ch_count[c*16 +: 16] !== m_cc[c][15:0]) begin errors++; $display("FAIL R9 count%0d got %h exp %h", c, ch_count[c*16 +: 16], m_cc[c][15:0]); end
    end
    if (io_rdata !== m_rd[7:0]) begin errors++; $display("FAIL R4 rdata got %h exp %h", io_rdata, m_rd[7:0]); end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin errors++; $display("FAIL %s got %h exp %h", tag, got, exp); end
  endtask

  task automatic wr_port(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk); io_port = p; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd_port(input logic [3:0] p, output logic [7:0] d);
    @(negedge clk); io_port = p; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic wr16(input logic [3:0] p, input logic [15:0] v);
    wr_port(p, v[7:0]); wr_port(p, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] p, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_port(p, lo); rd_port(p, hi); v = {hi, lo};
  endtask

  task automatic pulse(input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer_step = 4'(1 << c);
      @(negedge clk); xfer_step = 0;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 mask", ch_mask, 4'hF);
    chk("R1 mode", ch_mode, 0);
    chk("R1 count", ch_count[31:0], 0);
    chk("R1 rdata", io_rdata, 0);
    // R2 / R12: count of channel 1 at port 3
    wr16(4'h3, 16'h1234);
    chk("R2 R12 ch1 count", ch_count[31:16], 16'h1234);
    rd16(4'h3, w);
    chk("R4 ch1 count read", w, 16'h1234);
    // R3: desync pointer, then clear it
    wr_port(4'h0, 8'hAA);
    wr_port(4'hC, 8'h00);
    wr16(4'h0, 16'h6655);
    rd16(4'h0, w);
    chk("R3 ch0 addr after ptr clear", w, 16'h6655);
    // R5 single mask
    wr_port(4'hA, 8'h01); chk("R5 unmask ch1", ch_mask, 4'hD);
    wr_port(4'hA, 8'h05); chk("R5 mask ch1", ch_mask, 4'hF);
    wr_port(4'hA, 8'h02); chk("R5 unmask ch2", ch_mask, 4'hB);
    // R6 group mask
    wr_port(4'hF, 8'hF5); chk("R6 mask all", ch_mask, 4'h5);
    wr_port(4'hE, 8'h00); chk("R6 clear mask", ch_mask, 4'h0);
    // R7 modes
    wr_port(4'hB, 8'h45); chk("R7 ch1 mode", ch_mode[11:6], 6'h11);
    wr_port(4'hB, 8'h5A); chk("R7 ch2 mode", ch_mode[17:12], 6'h16);
    wr_port(4'hB, 8'hC3); chk("R7 ch3 mode", ch_mode[23:18], 6'h30);
    // R9 increment steps
    wr16(4'h2, 16'h0100);
    pulse(1, 3);
    chk("R9 ch1 count", ch_count[31:16], 16'h1231);
    rd16(4'h2, w); chk("R9 ch1 addr", w, 16'h0103);
    // R10 terminal count without auto-init
    wr_port(4'hB, 8'h44);
    wr16(4'h1, 16'h0001);
    pulse(0, 2);
    chk("R10 ch0 count wrap", ch_count[15:0], 16'hFFFF);
    chk("R10 ch0 masked at tc", ch_mask[0], 1'b1);
    rd_port(4'h8, b); chk("R11 status tc0", b, 8'h01);
    rd_port(4'h8, b); chk("R11 status cleared by read", b, 8'h00);
    // R10 auto-init reload
    wr16(4'h4, 16'h1000);
    wr16(4'h5, 16'h0002);
    pulse(2, 3);
    chk("R10 ch2 count reload", ch_count[47:32], 16'h0002);
    chk("R10 ch2 stays unmasked", ch_mask[2], 1'b0);
    rd16(4'h4, w); chk("R10 ch2 addr reload", w, 16'h1000);
    rd_port(4'h8, b); chk("R10 R11 status tc2", b, 8'h04);
    // R9 decrement
    wr_port(4'hB, 8'h67);
    wr16(4'h6, 16'h0010);
    wr16(4'h7, 16'h0005);
    pulse(3, 1);
    rd16(4'h6, w); chk("R9 ch3 addr dec", w, 16'h000F);
    chk("R9 ch3 count", ch_count[63:48], 16'h0004);
    // R12 step blocked during load
    @(negedge clk); io_port = 4'h7; io_wdata = 8'h09; io_wr = 1; xfer_step = 4'h8;
    @(negedge clk); io_wr = 0; xfer_step = 0;
    chk("R12 load wins over step", ch_count[63:48], 16'h0009);
    wr_port(4'h7, 8'h00);
    // R11 request bits
    wr_port(4'h9, 8'h06);
    rd_port(4'h8, b); chk("R11 request ch2", b, 8'h40);
    wr_port(4'h9, 8'h02);
    rd_port(4'h8, b); chk("R11 request cleared", b, 8'h00);
    // R8 master clear
    wr_port(4'h9, 8'h05);
    wr_port(4'h0, 8'h77);
    wr_port(4'hD, 8'h00);
    chk("R8 masks set", ch_mask, 4'hF);
    chk("R8 mode kept", ch_mode[11:6], 6'h11);
    rd_port(4'h8, b); chk("R8 status cleared", b, 8'h00);
    wr16(4'h0, 16'h1357);
    rd16(4'h0, w); chk("R8 pointer cleared", w, 16'h1357);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule